// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block performs one write at a time into an asynchronous static RAM. A client offers an address and a data word with a valid/ready handshake. The block then drives the memory pins through a fixed series of phases. First the address alone is presented. Then the active-low write strobe falls and the data bus is driven. Then the strobe rises while address and data stay put for a hold interval. A single-cycle completion pulse closes the transaction.

The length of each phase is a number of clock cycles taken from a configuration input at the moment the phase begins. The address-setup phase and the hold phase each have their own count. The strobe phase lasts the larger of two counts: a data-setup count and a minimum pulse-width count. A count of zero is stretched to one cycle. A new request may be accepted either from idle or in the completion cycle itself, so writes can run back to back without an idle gap.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, `mem_we_n` is 1, `mem_oe` is 0, `done` is 0, `req_ready` is 1 and `mem_addr` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `mem_addr` shows the request address from the next cycle on. `mem_we_n` stays 1 for exactly max(`cfg_asu`,1) cycles before it falls.
- R3: `mem_we_n` stays 0 for exactly max(`cfg_dsu`,`cfg_wpw`,1) cycles. `mem_oe` rises in the same cycle that `mem_we_n` falls. `mem_data` holds the request data from that cycle on.
- R4: After `mem_we_n` rises, `mem_addr` and `mem_data` stay unchanged and `mem_oe` stays 1 for exactly max(`cfg_hld`,1) cycles. `mem_oe` then falls to 0.
- R5: `done` is 1 for exactly one cycle, in the cycle that `mem_oe` falls. `req_ready` is 1 only while idle or while `done` is 1. `req_valid` has no effect on any output while `req_ready` is 0.
- R6: A configured count of zero in any phase produces a one-cycle phase.
- R7: `mem_addr` never changes while `mem_we_n` is 0, or in the cycle right after a cycle in which it was 0.
- R8: A request accepted in the `done` cycle starts its address-setup phase in the very next cycle, with the new address on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_addr | input | AW | Address of the offered write |
| req_data | input | DW | Data of the offered write |
| req_ready | output | 1 | Block can accept a request this cycle |
| cfg_asu | input | CW | Address-setup cycles |
| cfg_dsu | input | CW | Data-setup cycles |
| cfg_wpw | input | CW | Minimum write-pulse cycles |
| cfg_hld | input | CW | Address/data hold cycles |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Memory address pins |
| mem_data | output | DW | Memory data pins (valid when `mem_oe` is 1) |
| mem_oe | output | 1 | Drive enable for the memory data bus |
| mem_we_n | output | 1 | Active-low memory write strobe |

## Verification
A wrong internal state or a wrong counter load shows at the pins within the phase it corrupts. The edge of `mem_we_n` or `mem_oe` moves by one or more cycles, or the completion pulse arrives early or late. Measuring each edge relative to the accept edge exposes such an error in the same transaction. A wrong register enable shows up as an address or data change while the strobe or the bus drive is active, which the per-cycle comparison catches in the very cycle it happens. Back-to-back writes and requests offered while busy test whether the handshake leaks into a running transaction.

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  input  logic [CW-1:0] cfg_asu,
  input  logic [CW-1:0] cfg_dsu,
  input  logic [CW-1:0] cfg_wpw,
  input  logic [CW-1:0] cfg_hld,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mem_oe,
  output logic          mem_we_n
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_DONE} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_ld;
  logic [DW-1:0] dat_q;

  function automatic logic [CW-1:0] span(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  wire [CW-1:0] strobe_cfg = (cfg_dsu > cfg_wpw) ? cfg_dsu : cfg_wpw;
  wire          accept     = req_valid && req_ready;
  wire          last       = (cnt == '0);

  assign req_ready = (st == S_IDLE) || (st == S_DONE);

  always_comb begin
    st_nx  = st;
    cnt_ld = '0;
    case (st)
      S_IDLE, S_DONE: begin
        if (accept) begin
          st_nx  = S_SETUP;
          cnt_ld = span(cfg_asu);
        end else begin
          st_nx = S_IDLE;
        end
      end
      S_SETUP: if (last) begin
        st_nx  = S_STROBE;
        cnt_ld = span(strobe_cfg);
      end
      S_STROBE: if (last) begin
        st_nx  = S_HOLD;
        cnt_ld = span(cfg_hld);
      end
      S_HOLD: if (last) st_nx = S_DONE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      dat_q    <= '0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_we_n <= 1'b1;
      mem_oe   <= 1'b0;
      done     <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= cnt_ld;
      else if (!last)  cnt <= cnt - 1'b1;
      if (accept) begin
        mem_addr <= req_addr;
        dat_q    <= req_data;
      end
      if (st_nx == S_STROBE && st != S_STROBE) mem_data <= dat_q;
      mem_we_n <= (st_nx != S_STROBE);
      mem_oe   <= (st_nx == S_STROBE) || (st_nx == S_HOLD);
      done     <= (st_nx == S_DONE);
    end
  end

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          mem_oe,
  input logic          mem_we_n
);

  a_r7_addr_still_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr));

  a_r3_bus_driven_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe);

  a_r4_data_still_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |=> (!mem_oe || $stable(mem_data)));

  a_r4_drive_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_oe);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_busy_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !req_ready);

  a_r2_addr_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(req_valid && req_ready));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_oe(mem_oe), .mem_we_n(mem_we_n)
);

// File: tb/sim_sram_wr_seq.sv
module sim_sram_wr_seq;
  localparam int AW = 16, DW = 16, CW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] cfg_asu = 0, cfg_dsu = 0, cfg_wpw = 0, cfg_hld = 0;
  logic req_ready, done, mem_oe, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .cfg_asu(cfg_asu),
    .cfg_dsu(cfg_dsu), .cfg_wpw(cfg_wpw), .cfg_hld(cfg_hld), .done(done),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_oe(mem_oe), .mem_we_n(mem_we_n)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int atl1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // Called at the negedge just after the accept edge; returns at the done negedge.
  task automatic measure(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit spur);
    int ns = atl1(cfg_asu);
    int np = atl1((cfg_dsu > cfg_wpw) ? cfg_dsu : cfg_wpw);
    int nh = atl1(cfg_hld);
    int kd = ns + np + nh + 1;
    int k_fall = -1, k_rise = -1, k_oe = -1, k_done = -1;
    int addr_bad = 0, data_bad = 0, ready_bad = 0;
    logic [DW-1:0] dlast = '0;
    if (spur) begin
      req_valid = 1; req_addr = ~a; req_data = ~d;
    end else req_valid = 0;
    for (int k = 1; k <= kd + 50; k++) begin
      if (spur && k == kd - 1) req_valid = 0;
      if (mem_addr != a) addr_bad++;
      if (k_fall < 0 && !mem_we_n) begin k_fall = k; dlast = mem_data; end
      if (k_fall > 0 && k_rise < 0 && mem_we_n) k_rise = k;
      if (k_fall > 0 && k_oe < 0 && !mem_oe) k_oe = k;
      if (mem_oe && mem_data != dlast) data_bad++;
      if (k_done < 0 && done) k_done = k;
      if (k_done < 0 && req_ready) ready_bad++;
      if (k_done > 0) break;
      @(negedge clk);
    end
    chk("R2 setup cycles", k_fall - 1, ns);
    chk("R3 strobe cycles", k_rise - k_fall, np);
    chk("R3 data at strobe", dlast, d);
    chk("R4 hold cycles", k_oe - k_rise, nh);
    chk("R7 address steady", addr_bad, 0);
    chk("R4 data steady while driven", data_bad, 0);
    chk("R5 done cycle", k_done, kd);
    chk("R5 done with drive off", k_done, k_oe);
    chk("R5 busy not ready", ready_bad, 0);
    chk("R5 ready at done", req_ready, 1);
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_addr = a; req_data = d;
    @(negedge clk);
  endtask

  task automatic single(input int s, input int ds, input int p, input int h,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input bit spur);
    cfg_asu = s; cfg_dsu = ds; cfg_wpw = p; cfg_hld = h;
    chk("R5 ready when idle", req_ready, 1);
    issue(a, d);
    measure(a, d, spur);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe", mem_oe, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 addr", mem_addr, 0);
  endtask

  task automatic t_chain;
    cfg_asu = 2; cfg_dsu = 1; cfg_wpw = 3; cfg_hld = 2;
    issue(16'h1111, 16'haaaa);
    measure(16'h1111, 16'haaaa, 0);
    issue(16'h2222, 16'h5555);   // R8: accepted in the done cycle
    chk("R8 new address next cycle", mem_addr, 16'h2222);
    measure(16'h2222, 16'h5555, 0);
    @(negedge clk);
  endtask

  task automatic t_ignore;
    single(3, 2, 2, 1, 16'h0f0f, 16'h1234, 1);
    repeat (3) @(negedge clk);
    chk("R5 busy request not taken", mem_addr, 16'h0f0f);
    chk("R5 idle after done", mem_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    single(2, 3, 1, 2, 16'h00a5, 16'hbeef, 0);
    single(1, 1, 4, 3, 16'h7ffe, 16'h0001, 0);   // pulse width larger
    single(4, 5, 2, 1, 16'h8001, 16'hfffe, 0);   // data setup larger
    single(0, 0, 0, 0, 16'h3c3c, 16'hc3c3, 0);   // R6 all zero
    single(0, 2, 0, 0, 16'h4444, 16'h0808, 0);   // R6 mixed
    t_chain;
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule